// File: doc/BRIEF.md
# I2C Register-Access Slave

This block is an I2C target that lets an external host read and write a byte-wide register file through a two-wire bus. SCL and SDA are open-drain lines. The block sees each line as a plain input and pulls SDA low through a single output-enable. On the inside, it drives a simple register bus. That bus carries an address, write data and a write strobe. It also has a read strobe, and the read data returns one cycle after that strobe.

The block answers only to one fixed 7-bit device address. It keeps an 8-bit register pointer that advances by itself. In a write transfer, the first data byte loads the pointer, and every later byte is stored at the pointer, which then steps forward. In a read transfer, the block sends the bytes found at the pointer and steps the pointer after each byte. A repeated start leaves the pointer as it is. A host can therefore set the pointer with a short write and then read from that location within the same transfer. Both lines pass through a two-flop synchroniser before any edge is detected, so the system clock must run at least eight times faster than SCL.

Top module: `i2c_reg_slave`

## Requirements
- R1: The block acknowledges an address byte whose upper seven bits equal DEV_ADDR (default binary 0101010). It does this by pulling SDA low during the ninth clock. Bit 0 of the address byte selects the direction: 0 means write, 1 means read.
- R2: In a write transfer, the first data byte loads the register pointer. Each later byte gives one reg_we_o pulse at the current pointer, after which the pointer steps by one. Every byte received in a write transfer is acknowledged.
- R3: A read transfer sends the bytes stored at the pointer, MSB first, and steps the pointer after each byte sent. A read that follows no pointer write continues from wherever the pointer was left.
- R4: A repeated start keeps the pointer. A write of one pointer byte, followed by a repeated start and a read, therefore returns data from that pointer.
- R5: While reading, a master ACK (SDA low) makes the block send the next byte. A NACK (SDA high) makes the block release SDA until the next start or stop.
- R6: The pointer wraps from 0xFF to 0x00, for both writes and reads.
- R7: When the address does not match, the block gives no acknowledge and makes no register access. It then ignores the bus until the next start.
- R8: A start or stop at any bit position abandons the byte in progress. A start always begins a fresh address byte.
- R9: The block changes SDA only while SCL is low. It keeps SDA released outside the acknowledge bits and outgoing zero bits, including while idle and after reset.
- R10: reg_we_o and reg_re_o are single-cycle pulses and never occur together. reg_rdata_i is taken in the cycle after reg_re_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| reg_addr_o | output | 8 | Register address for a read or write |
| reg_wdata_o | output | 8 | Register write data |
| reg_we_o | output | 1 | One-cycle register write strobe |
| reg_re_o | output | 1 | One-cycle register read strobe |
| reg_rdata_i | input | 8 | Register read data, valid the cycle after reg_re_o |

## Verification
The bench builds the block with DEV_ADDR at 0x2A and SYNC_STAGES at 2, and sets SCL to one twentieth of the system clock. With these values, the bench sweeps all 128 address bytes with the write direction, which covers every non-matching address as well as the matching one. A 32-byte burst that starts at 0xF0 crosses the pointer wrap in both the write and the read direction. Single starts and stops inserted partway through a byte reach the bit-counter reset at several bit positions.

// File: rtl/i2c_slv_pkg.sv
package i2c_slv_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_RX,
        ST_RX_ACK,
        ST_TX,
        ST_TX_ACK,
        ST_SKIP
    } slv_state_e;

    typedef struct packed {
        slv_state_e          st;
        logic [CNT_W-1:0]    cnt;
        logic [BYTE_W-1:0]   sh;
        logic [BYTE_W-1:0]   ptr;
        logic                first;
        logic                rw;
        logic                oe;
        logic                nack;
        logic                we;
        logic                re;
        logic                rd_pend;
        logic [BYTE_W-1:0]   addr;
        logic [BYTE_W-1:0]   wdata;
    } slv_regs_t;

    typedef struct packed {
        logic scl_prev;
        logic sda_prev;
    } cond_regs_t;

endpackage

// File: rtl/i2c_slv_sync.sv
module i2c_slv_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [STAGES-1:0][W-1:0] stg_d;
    logic [STAGES-1:0][W-1:0] stg_q;

    // Idle bus lines are high, so the chain resets to ones.
    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                assign stg_d[g] = d_i;
            end else begin : g_next
                assign stg_d[g] = stg_q[g-1];
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= '1;
        else        stg_q <= stg_d;
    end

    assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/i2c_slv_cond.sv
module i2c_slv_cond
    import i2c_slv_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    cond_regs_t c_d, c_q;

    always_comb begin
        c_d.scl_prev = scl_s;
        c_d.sda_prev = sda_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '{scl_prev: 1'b1, sda_prev: 1'b1};
        else        c_q <= c_d;
    end

    assign scl_rise_o = scl_s & ~c_q.scl_prev;
    assign scl_fall_o = ~scl_s & c_q.scl_prev;
    // A data-line edge while the clock stays high is a bus condition.
    assign start_o    = c_q.sda_prev & ~sda_s & scl_s & c_q.scl_prev;
    assign stop_o     = ~c_q.sda_prev & sda_s & scl_s & c_q.scl_prev;

    a_r8_no_both_conditions: assert property (@(posedge clk) disable iff (!rst_n)
        !(start_o && stop_o));
endmodule

// File: rtl/i2c_slv_fsm.sv
module i2c_slv_fsm
    import i2c_slv_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h2A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_lvl_i,
    input  logic              sda_lvl_i,
    input  logic              scl_rise_i,
    input  logic              scl_fall_i,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic [BYTE_W-1:0] rdata_i,
    output logic              oe_o,
    output logic [BYTE_W-1:0] addr_o,
    output logic [BYTE_W-1:0] wdata_o,
    output logic              we_o,
    output logic              re_o
);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

    slv_regs_t q, d;

    always_comb begin
        d         = q;
        d.we      = 1'b0;
        d.re      = 1'b0;
        d.rd_pend = q.re;
        if (q.rd_pend) d.sh = rdata_i;

        if (start_i) begin
            d.st    = ST_ADDR;
            d.cnt   = '0;
            d.first = 1'b1;
            d.oe    = 1'b0;
        end else if (stop_i) begin
            d.st  = ST_IDLE;
            d.cnt = '0;
            d.oe  = 1'b0;
        end else begin
            unique case (q.st)
                ST_ADDR: begin
                    if (scl_rise_i && q.cnt < LAST_BIT) begin
                        d.sh  = {q.sh[BYTE_W-2:0], sda_lvl_i};
                        d.cnt = q.cnt + 1'b1;
                    end else if (scl_fall_i && q.cnt == LAST_BIT) begin
                        if (q.sh[BYTE_W-1:1] == DEV_ADDR) begin
                            d.st = ST_ADDR_ACK;
                            d.oe = 1'b1;
                            d.rw = q.sh[0];
                            if (q.sh[0]) begin
                                d.re   = 1'b1;
                                d.addr = q.ptr;
                            end
                        end else begin
                            d.st = ST_SKIP;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall_i) begin
                        d.cnt = '0;
                        if (q.rw) begin
                            d.st = ST_TX;
                            d.oe = ~q.sh[BYTE_W-1];
                        end else begin
                            d.st = ST_RX;
                            d.oe = 1'b0;
                        end
                    end
                end
                ST_RX: begin
                    if (scl_rise_i && q.cnt < LAST_BIT) begin
                        d.sh  = {q.sh[BYTE_W-2:0], sda_lvl_i};
                        d.cnt = q.cnt + 1'b1;
                    end else if (scl_fall_i && q.cnt == LAST_BIT) begin
                        d.st = ST_RX_ACK;
                        d.oe = 1'b1;
                        if (q.first) begin
                            d.ptr   = q.sh;
                            d.first = 1'b0;
                        end else begin
                            d.we    = 1'b1;
                            d.addr  = q.ptr;
                            d.wdata = q.sh;
                            d.ptr   = q.ptr + 1'b1;
                        end
                    end
                end
                ST_RX_ACK: begin
                    if (scl_fall_i) begin
                        d.st  = ST_RX;
                        d.oe  = 1'b0;
                        d.cnt = '0;
                    end
                end
                ST_TX: begin
                    if (scl_rise_i && q.cnt < LAST_BIT) begin
                        d.cnt = q.cnt + 1'b1;
                    end else if (scl_fall_i) begin
                        if (q.cnt == LAST_BIT) begin
                            d.st  = ST_TX_ACK;
                            d.oe  = 1'b0;
                            d.ptr = q.ptr + 1'b1;
                        end else if (q.cnt != '0) begin
                            d.sh = {q.sh[BYTE_W-2:0], 1'b0};
                            d.oe = ~q.sh[BYTE_W-2];
                        end
                    end
                end
                ST_TX_ACK: begin
                    if (scl_rise_i) begin
                        d.nack = sda_lvl_i;
                        if (!sda_lvl_i) begin
                            d.re   = 1'b1;
                            d.addr = q.ptr;
                        end
                    end else if (scl_fall_i) begin
                        d.cnt = '0;
                        if (q.nack) begin
                            d.st = ST_SKIP;
                        end else begin
                            d.st = ST_TX;
                            d.oe = ~q.sh[BYTE_W-1];
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.st    <= ST_IDLE;
            q.first <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign oe_o    = q.oe;
    assign addr_o  = q.addr;
    assign wdata_o = q.wdata;
    assign we_o    = q.we;
    assign re_o    = q.re;

    a_r1_ack_own_addr: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(q.st) == ST_ADDR && q.st == ST_ADDR_ACK) |-> ($past(q.sh[BYTE_W-1:1]) == DEV_ADDR));
    a_r2_write_from_rx: assert property (@(posedge clk) disable iff (!rst_n)
        q.we |-> ($past(q.st) == ST_RX));
    a_r7_skip_released: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_SKIP) |-> !q.oe);
    a_r8_start_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (q.st == ST_ADDR && q.cnt == '0));
    a_r9_sda_moves_low: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(q.oe) || !$past(scl_lvl_i) || $past(start_i || stop_i));
    a_r10_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(q.we && q.re));
    a_r10_we_single: assert property (@(posedge clk) disable iff (!rst_n)
        q.we |=> !q.we);
    a_r10_re_single: assert property (@(posedge clk) disable iff (!rst_n)
        q.re |=> !q.re);
endmodule

// File: rtl/i2c_reg_slave.sv
module i2c_reg_slave
    import i2c_slv_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h2A,
    parameter int         SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe_o,
    output logic [7:0] reg_addr_o,
    output logic [7:0] reg_wdata_o,
    output logic       reg_we_o,
    output logic       reg_re_o,
    input  logic [7:0] reg_rdata_i
);
    logic [1:0] lines_s;
    logic scl_rise, scl_fall, bus_start, bus_stop;

    i2c_slv_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({scl_i, sda_i}),
        .q_o   (lines_s)
    );

    i2c_slv_cond u_cond (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_s      (lines_s[1]),
        .sda_s      (lines_s[0]),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (bus_start),
        .stop_o     (bus_stop)
    );

    i2c_slv_fsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_lvl_i  (lines_s[1]),
        .sda_lvl_i  (lines_s[0]),
        .scl_rise_i (scl_rise),
        .scl_fall_i (scl_fall),
        .start_i    (bus_start),
        .stop_i     (bus_stop),
        .rdata_i    (reg_rdata_i),
        .oe_o       (sda_oe_o),
        .addr_o     (reg_addr_o),
        .wdata_o    (reg_wdata_o),
        .we_o       (reg_we_o),
        .re_o       (reg_re_o)
    );
endmodule

// File: tb/i2c_reg_slave_test.sv
module i2c_reg_slave_test;
    localparam int Q = 5;
    localparam logic [6:0] DEV = 7'h2A;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe, we, re;
    logic [7:0] addr, wdata, rdata;
    wire  sda_line = sda_m & ~sda_oe;

    i2c_reg_slave #(.DEV_ADDR(DEV), .SYNC_STAGES(2)) uut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .sda_oe_o(sda_oe), .reg_addr_o(addr), .reg_wdata_o(wdata),
        .reg_we_o(we), .reg_re_o(re), .reg_rdata_i(rdata)
    );

    function automatic logic [7:0] pat(int i);
        return 8'((i * 3) + 90);
    endfunction

    logic [7:0] mem [256];
    int we_cnt;
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] <= pat(i);
            we_cnt <= 0;
            rdata  <= '0;
        end else begin
            if (we) begin
                mem[addr] <= wdata;
                we_cnt    <= we_cnt + 1;
            end
            if (re) rdata <= mem[addr];
        end
    end

    logic [7:0] exp_mem [256];
    int checks = 0, errors = 0;
    bit done = 0;

    task automatic chk(bit ok, string req, string what, int act, int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s got %0h exp %0h", req, what, act, expv);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(2 * Q);
    endtask

    task automatic send_bit(logic b);
        sda_m = b; tick(Q);
        scl_m = 1'b1; tick(2 * Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic write_byte(logic [7:0] v, output bit ack);
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        ack = !sda_line; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic read_byte(bit mack, output logic [7:0] v, output bit steady);
        logic s0;
        steady = 1;
        v = '0;
        for (int i = 0; i < 8; i++) begin
            sda_m = 1'b1; tick(Q);
            scl_m = 1'b1; tick(1);
            s0 = sda_line; tick(2 * Q - 2);
            if (sda_line !== s0) steady = 0;
            v = {v[6:0], s0};
            tick(1);
            scl_m = 1'b0; tick(Q);
        end
        send_bit(!mack);
        sda_m = 1'b1;
    endtask

    task automatic wr_burst(logic [7:0] p, int n, int seed);
        bit ack;
        int base;
        bus_start();
        write_byte({DEV, 1'b0}, ack); chk(ack, "R1", "write address ack", ack, 1);
        write_byte(p, ack);           chk(ack, "R2", "pointer byte ack", ack, 1);
        base = we_cnt;
        for (int i = 0; i < n; i++) begin
            logic [7:0] v;
            v = 8'((i * 37) + seed);
            write_byte(v, ack);
            chk(ack, "R2", "data byte ack", ack, 1);
            exp_mem[8'(p + i)] = v;
        end
        bus_stop();
        chk(we_cnt == base + n, "R10", "write strobe count", we_cnt - base, n);
    endtask

    initial begin
        bit ack, st;
        logic [7:0] v;
        int errs;
        for (int i = 0; i < 256; i++) exp_mem[i] = pat(i);
        tick(4);
        chk(sda_oe == 0 && we == 0 && re == 0, "R9", "reset outputs", {sda_oe, we, re}, 0);
        rst_n = 1'b1;
        tick(10);
        chk(sda_oe == 0, "R9", "idle release", sda_oe, 0);

        // Sweep every 7-bit address with the write direction.
        for (int a = 0; a < 128; a++) begin
            int base;
            base = we_cnt;
            bus_start();
            write_byte({7'(a), 1'b0}, ack);
            if (a == int'(DEV)) begin
                chk(ack, "R1", "own address ack", ack, 1);
                write_byte(8'h00, ack);
                chk(ack, "R2", "pointer ack", ack, 1);
            end else begin
                chk(!ack, "R7", "foreign address nack", ack, 0);
                write_byte(8'h77, ack);
                chk(!ack && we_cnt == base, "R7", "foreign data ignored", {ack, 8'(we_cnt - base)}, 0);
            end
            bus_stop();
        end

        // Burst crossing the pointer wrap.
        wr_burst(8'hF0, 32, 3);
        errs = 0;
        for (int i = 0; i < 256; i++) if (mem[i] !== exp_mem[i]) errs++;
        chk(errs == 0, "R6", "register file after wrapping write", errs, 0);

        // Combined write-pointer then repeated-start read.
        bus_start();
        write_byte({DEV, 1'b0}, ack);
        write_byte(8'hF0, ack);
        bus_start();
        write_byte({DEV, 1'b1}, ack); chk(ack, "R4", "read address ack", ack, 1);
        for (int i = 0; i < 32; i++) begin
            read_byte(i != 31, v, st);
            chk(v == exp_mem[8'(8'hF0 + i)], "R4", "combined read data", v, exp_mem[8'(8'hF0 + i)]);
            chk(st, "R9", "sda steady while scl high", st, 1);
        end
        tick(Q);
        chk(sda_oe == 0, "R5", "released after nack", sda_oe, 0);
        bus_stop();
        chk(sda_oe == 0, "R5", "released after stop", sda_oe, 0);

        // Current-address read continues at 0x10.
        bus_start();
        write_byte({DEV, 1'b1}, ack); chk(ack, "R1", "read address ack", ack, 1);
        for (int i = 0; i < 4; i++) begin
            read_byte(i != 3, v, st);
            chk(v == exp_mem[8'h10 + i], "R3", "current-address read", v, exp_mem[8'h10 + i]);
        end
        bus_stop();

        // Read wrap from 0xFF into 0x00.
        bus_start();
        write_byte({DEV, 1'b0}, ack);
        write_byte(8'hFF, ack);
        bus_start();
        write_byte({DEV, 1'b1}, ack);
        read_byte(1, v, st); chk(v == exp_mem[8'hFF], "R6", "read at 0xFF", v, exp_mem[8'hFF]);
        read_byte(0, v, st); chk(v == exp_mem[8'h00], "R6", "read wraps to 0x00", v, exp_mem[8'h00]);
        bus_stop();

        // Start and stop in the middle of bytes.
        for (int k = 1; k < 8; k += 3) begin
            bus_start();
            for (int b = 0; b < k; b++) send_bit(1'b1);
            bus_start();
            write_byte({DEV, 1'b0}, ack);
            chk(ack, "R8", "address after mid-byte start", ack, 1);
            write_byte(8'(8'h40 + k), ack);
            write_byte(8'(8'hA0 + k), ack);
            exp_mem[8'h40 + k] = 8'(8'hA0 + k);
            bus_stop();
            tick(4);
            chk(mem[8'h40 + k] == exp_mem[8'h40 + k], "R8", "write after restart", mem[8'h40 + k], exp_mem[8'h40 + k]);
        end
        bus_start();
        write_byte({DEV, 1'b0}, ack);
        send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
        bus_stop();
        wr_burst(8'h60, 2, 11);
        tick(4);
        chk(mem[8'h60] == exp_mem[8'h60] && mem[8'h61] == exp_mem[8'h61], "R8", "write after mid-byte stop",
            mem[8'h61], exp_mem[8'h61]);
        chk(mem[8'h40] == exp_mem[8'h40], "R2", "untouched register kept", mem[8'h40], exp_mem[8'h40]);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired got %0d exp %0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule